// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one logic cell of a small programmable logic fabric. It reads a shared input bus and builds five AND terms from it. Each term can take any bus signal in true form, in complement form, or not at all. A static configuration word decides how each term is used. A term can join the local OR sum, or it can serve one of several roles: the second XOR operand, the register data, the register clock enable, the register asynchronous clear, or the output enable.

The local sum is ORed with a sum arriving from a neighbouring cell. The combined sum leaves on the cascade output, so chained cells can pool their terms. The combined sum then passes through an XOR stage. That stage inverts the sum, passes it unchanged, or XORs it with a term, which is how a D register can act as a toggle flip-flop.

The pad output carries either the XOR result or the register output. It is enabled always, never, or by a term. The feedback signal returned to the array carries either the pad value or the register output, so a register that is not driving the pad still stays visible to the array.

Top module: `plm_cell`

## Requirements
- R1: The configuration word is {ctl, cmask, tmask}, with tmask at the least significant end. Bit t*N_IN+i of tmask includes bus bit i in term t, and the same bit of cmask includes its complement. A term is the AND of its included literals. A term with no literals is 1, and a term that includes both forms of one bit is 0.
- R2: The local sum is the OR of every term t whose bit ctl[t] (ctl[4:0]) is set.
- R3: cas_out equals the local sum ORed with cas_in.
- R4: The XOR stage outputs cas_out XOR an operand. The operand comes from ctl[21:20]: 0 gives 0, 1 gives 1, and 2 or 3 gives the term indexed by ctl[7:5].
- R5: A term index field with a value of 5 or more reads as 0.
- R6: With ctl[22]=0 the register loads the XOR result. With ctl[22]=1 it loads the term indexed by ctl[10:8]. It loads on the rising clock edge.
- R7: With ctl[25]=1 the register loads only when the term indexed by ctl[16:14] is 1; otherwise it holds its value. With ctl[25]=0 it loads on every edge.
- R8: The register clears to 0 at once while rst_n is low. With ctl[26]=1 it also clears at once, without waiting for a clock edge, while the term indexed by ctl[19:17] is 1.
- R9: pad_drv carries the XOR result when ctl[27]=0 and the register output when ctl[27]=1.
- R10: pad_en follows ctl[24:23]. A value of 0 gives 0, 1 gives 1, and 2 or 3 gives the term indexed by ctl[13:11]. When pad_en is 0 the pad is undriven.
- R11: When ctl[28]=0, fb_out carries the pad value: pad_drv if pad_en is 1, otherwise pad_in. When ctl[28]=1, fb_out carries the register output.
- R12: Suppose fb_out is returned on bus bit 0, the XOR operand is a term holding only that bit, and the sum is 1. The register then toggles on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 2*5*N_IN+29 | Static configuration word |
| bus_in | input | N_IN | Shared array input bus |
| cas_in | input | 1 | Sum from the neighbouring cell |
| pad_in | input | 1 | Value seen on the pad when it is not driven |
| cas_out | output | 1 | Local sum ORed with cas_in |
| pad_drv | output | 1 | Pad output data |
| pad_en | output | 1 | Pad output enable |
| fb_out | output | 1 | Feedback to the array |

## Verification
A wrong term mask or a wrong steering decode shows up the same cycle on cas_out or on the combinational pad_drv, because no register sits on that path. A register fault shows up one edge late, and only when the configuration makes the register visible, through the registered output select or the feedback select. The bench therefore turns on those paths, as in the buried-register and toggle cases. An asynchronous clear that fails to act is visible before the next edge, so the bench samples it between edges.

// File: rtl/plm_pkg.sv
`timescale 1ns/1ps
package plm_pkg;
  localparam int NPT   = 5;
  localparam int IDX_W = 3;
  localparam int CTL_W = 29;

  typedef struct packed {
    logic             fb_q;
    logic             out_reg;
    logic             ar_en;
    logic             ce_en;
    logic [1:0]       oe_mode;
    logic             d_term;
    logic [1:0]       xor_mode;
    logic [IDX_W-1:0] ar_pt;
    logic [IDX_W-1:0] ce_pt;
    logic [IDX_W-1:0] oe_pt;
    logic [IDX_W-1:0] d_pt;
    logic [IDX_W-1:0] xor_pt;
    logic [NPT-1:0]   to_or;
  } ctl_t;

  // A term picked by index; out-of-range indices read as 0.
  function automatic logic pick_term(logic [NPT-1:0] t, logic [IDX_W-1:0] idx);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NPT; k++)
      if (idx == IDX_W'(k)) r = t[k];
    return r;
  endfunction

  // mode[1] selects a term, else mode[0] is the fixed level.
  function automatic logic mode_pick(logic [1:0] mode, logic term_v);
    return mode[1] ? term_v : mode[0];
  endfunction
endpackage

// File: rtl/plm_term_array.sv
`timescale 1ns/1ps
module plm_term_array #(
  parameter int N_IN = 8,
  parameter int N_T  = 5
) (
  input  logic [N_IN-1:0]     bus,
  input  logic [N_T*N_IN-1:0] tmask,
  input  logic [N_T*N_IN-1:0] cmask,
  output logic [N_T-1:0]      terms
);
  for (genvar t = 0; t < N_T; t++) begin : g_term
    logic [N_IN-1:0] tm, cm, lit_ok;
    assign tm     = tmask[t*N_IN +: N_IN];
    assign cm     = cmask[t*N_IN +: N_IN];
    assign lit_ok = (bus | ~tm) & (~bus | ~cm);
    assign terms[t] = &lit_ok;
  end
endmodule

// File: rtl/plm_route.sv
`timescale 1ns/1ps
module plm_route
  import plm_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPT-1:0] terms,
  input  ctl_t           ctl,
  input  logic           cas_in,
  output logic           sum_o,
  output logic           xor_o,
  output logic           d_o,
  output logic           ce_o,
  output logic           ar_o,
  output logic           oe_o
);
  logic local_sum, xor_opnd;

  assign local_sum = |(terms & ctl.to_or);
  assign sum_o     = local_sum | cas_in;
  assign xor_opnd  = mode_pick(ctl.xor_mode, pick_term(terms, ctl.xor_pt));
  assign xor_o     = sum_o ^ xor_opnd;
  assign d_o       = ctl.d_term ? pick_term(terms, ctl.d_pt) : xor_o;
  assign ce_o      = ctl.ce_en ? pick_term(terms, ctl.ce_pt) : 1'b1;
  assign ar_o      = ctl.ar_en & pick_term(terms, ctl.ar_pt);
  assign oe_o      = mode_pick(ctl.oe_mode, pick_term(terms, ctl.oe_pt));

  // R3: an incoming neighbour sum always reaches the chain output
  a_r3_cascade_passes: assert property (@(posedge clk) disable iff (!rst_n)
    cas_in |-> sum_o);
  // R5: an out-of-range XOR term index behaves as a fixed 0 operand
  a_r5_bad_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.xor_mode[1] && ctl.xor_pt >= IDX_W'(NPT)) |-> (xor_o == sum_o));
endmodule

// File: rtl/plm_reg_stage.sv
`timescale 1ns/1ps
module plm_reg_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ar,
  input  logic ce,
  input  logic d,
  output logic q
);
  logic clr_n;
  assign clr_n = rst_n & ~ar;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)  q <= 1'b0;
    else if (ce) q <= d;
  end

  // R7: without enable or clear the stored bit holds
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !ar) |=> (q == $past(q) || ar));
  // R8: an active clear term forces the stored bit to 0
  a_r8_clear_term: assert property (@(posedge clk) disable iff (!rst_n)
    ar |-> !q);
  // R8: reset holds the stored bit at 0
  always @(posedge clk) if (!rst_n) a_r8_reset_zero: assert (!q);
endmodule

// File: rtl/plm_cell.sv
`timescale 1ns/1ps
module plm_cell
  import plm_pkg::*;
#(
  parameter int N_IN = 8,
  localparam int MW  = NPT * N_IN,
  localparam int CW  = 2 * MW + CTL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cfg,
  input  logic [N_IN-1:0] bus_in,
  input  logic            cas_in,
  input  logic            pad_in,
  output logic            cas_out,
  output logic            pad_drv,
  output logic            pad_en,
  output logic            fb_out
);
  ctl_t           ctl;
  logic [NPT-1:0] terms;
  logic           xor_v, d_v, ce_v, ar_v, oe_v, q_v, pad_val;

  assign ctl = ctl_t'(cfg[2*MW +: CTL_W]);

  plm_term_array #(.N_IN(N_IN), .N_T(NPT)) u_terms (
    .bus(bus_in), .tmask(cfg[0 +: MW]), .cmask(cfg[MW +: MW]), .terms(terms));

  plm_route u_route (
    .clk(clk), .rst_n(rst_n), .terms(terms), .ctl(ctl), .cas_in(cas_in),
    .sum_o(cas_out), .xor_o(xor_v), .d_o(d_v), .ce_o(ce_v), .ar_o(ar_v), .oe_o(oe_v));

  plm_reg_stage u_reg (
    .clk(clk), .rst_n(rst_n), .ar(ar_v), .ce(ce_v), .d(d_v), .q(q_v));

  assign pad_drv = ctl.out_reg ? q_v : xor_v;
  assign pad_en  = oe_v;
  assign pad_val = pad_en ? pad_drv : pad_in;
  assign fb_out  = ctl.fb_q ? q_v : pad_val;

  // R10: a disabled output mode never drives the pad
  a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.oe_mode == 2'd0) |-> !pad_en);
  // R11: pad feedback with the pad undriven shows the external value
  a_r11_pad_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.fb_q && !pad_en) |-> (fb_out == pad_in));
endmodule

// File: tb/plm_cell_tb_top.sv
`timescale 1ns/1ps
module plm_cell_tb_top;
  localparam int NI = 6;
  localparam int MW = 5 * NI;
  localparam int CW = 2 * MW + 29;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cfg = '0;
  logic [NI-1:0] bus = '0;
  logic cas_in = 1'b0, pad_in = 1'b0;
  logic cas_out, pad_drv, pad_en, fb_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  plm_cell #(.N_IN(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .bus_in(bus), .cas_in(cas_in),
    .pad_in(pad_in), .cas_out(cas_out), .pad_drv(pad_drv), .pad_en(pad_en),
    .fb_out(fb_out));

  function automatic logic [28:0] mkctl(logic fb, logic oreg, logic ar_en, logic ce_en,
      logic [1:0] os, logic dt, logic [1:0] xs, logic [2:0] apt, logic [2:0] cpt,
      logic [2:0] opt, logic [2:0] dpt, logic [2:0] xpt, logic [4:0] to_or);
    return {fb, oreg, ar_en, ce_en, os, dt, xs, apt, cpt, opt, dpt, xpt, to_or};
  endfunction

  // Reference: {cas_out, pad_drv, pad_en, fb_out} from configuration and inputs
  function automatic logic [3:0] ref_out(logic [CW-1:0] c, logic [NI-1:0] b,
      logic ci, logic pi, logic q);
    logic [4:0] tv;
    logic [28:0] k;
    logic s, opnd, x, en, drv, ev;
    int ix;
    k = c[2*MW +: 29];
    for (int t = 0; t < 5; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (c[t*NI+i] && !b[i]) tv[t] = 1'b0;
        if (c[MW+t*NI+i] && b[i]) tv[t] = 1'b0;
      end
    end
    s = ci;
    for (int t = 0; t < 5; t++) if (k[t] && tv[t]) s = 1'b1;
    ix = int'(k[7:5]);
    opnd = (k[21:20] >= 2) ? ((ix < 5) ? tv[ix] : 1'b0) : k[20];
    x = s ^ opnd;
    ix = int'(k[13:11]);
    ev = (ix < 5) ? tv[ix] : 1'b0;
    en = (k[24:23] >= 2) ? ev : k[23];
    drv = k[27] ? q : x;
    return {s, drv, en, k[28] ? q : (en ? drv : pi)};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [29:0] tm, cm;
    logic [4:0]  to_or;
    logic [2:0]  xpt;
    logic [1:0]  xs, os;
    logic [2:0]  opt;
    logic [5:0]  b;
    logic        ci, pi;
    logic [3:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{30'h0, 30'h0, 5'b00000, 3'd0, 2'd0, 2'd1, 3'd0, 6'b000000, 1'b0, 1'b0, 4'b0010},
    '{30'h0, 30'h0, 5'b00000, 3'd0, 2'd1, 2'd1, 3'd0, 6'b000000, 1'b0, 1'b0, 4'b0111},
    '{30'h6, 30'h0, 5'b00001, 3'd0, 2'd0, 2'd1, 3'd0, 6'b000110, 1'b0, 1'b0, 4'b1111},
    '{30'h6, 30'h0, 5'b00001, 3'd0, 2'd0, 2'd1, 3'd0, 6'b000010, 1'b0, 1'b0, 4'b0010},
    '{30'h0, 30'h0, 5'b00000, 3'd0, 2'd1, 2'd1, 3'd0, 6'b000000, 1'b1, 1'b0, 4'b1010},
    '{30'h0, 30'h200, 5'b00010, 3'd1, 2'd2, 2'd1, 3'd0, 6'b000000, 1'b0, 1'b0, 4'b1010},
    '{30'h0, 30'h0, 5'b00000, 3'd0, 2'd0, 2'd0, 3'd0, 6'b000000, 1'b0, 1'b1, 4'b0001},
    '{30'h1000, 30'h0, 5'b00000, 3'd0, 2'd1, 2'd2, 3'd2, 6'b000000, 1'b0, 1'b0, 4'b0100},
    '{30'h1000, 30'h0, 5'b00000, 3'd0, 2'd1, 2'd2, 3'd2, 6'b000001, 1'b0, 1'b0, 4'b0111},
    '{30'h0, 30'h0, 5'b10000, 3'd5, 2'd2, 2'd1, 3'd0, 6'b000000, 1'b0, 1'b0, 4'b1111},
    '{30'h400000, 30'h400000, 5'b01000, 3'd0, 2'd0, 2'd1, 3'd0, 6'b010000, 1'b0, 1'b0, 4'b0010}
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic prev;
    // Reset: register held at 0 even though D would be 1 (R8)
    cfg = {mkctl(1, 1, 0, 0, 2'd1, 0, 2'd1, 0, 0, 0, 0, 0, 5'b0), 30'h0, 30'h0};
    repeat (3) @(negedge clk);
    check("R8 reset", {pad_drv, fb_out}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 R9 registered xor", {pad_drv, fb_out}, 2'b11);

    // Combinational vector table (R1 R2 R3 R4 R5 R10 R11); ce term index 7 freezes the register
    for (int v = 0; v < NV; v++) begin
      cfg = {mkctl(0, 0, 0, 1, VT[v].os, 0, VT[v].xs, 0, 3'd7, VT[v].opt, 0,
                   VT[v].xpt, VT[v].to_or), VT[v].cm, VT[v].tm};
      bus = VT[v].b; cas_in = VT[v].ci; pad_in = VT[v].pi;
      @(negedge clk);
      check($sformatf("R1 R2 R3 R4 R10 R11 vector %0d", v),
            {cas_out, pad_drv, pad_en, fb_out}, VT[v].exp);
      check($sformatf("R1 R5 model vector %0d", v),
            {cas_out, pad_drv, pad_en, fb_out},
            ref_out(cfg, bus, cas_in, pad_in, 1'b0));
    end
    cas_in = 1'b0; pad_in = 1'b0;

    // R6 buried register: D from term0 (bus bit1 true) while pad stays combinational
    bus = '0;
    cfg = {mkctl(1, 0, 0, 0, 2'd1, 1, 2'd1, 0, 0, 0, 3'd0, 0, 5'b0), 30'h0, 30'h2};
    @(negedge clk);
    check("R6 buried term load", {pad_drv, fb_out}, 2'b10);
    bus = 6'b000010;
    @(negedge clk);
    check("R6 buried term load one", {pad_drv, fb_out}, 2'b11);

    // R7 clock enable from term1 (bus bit2), D = xor = const 0
    cfg = {mkctl(1, 0, 0, 1, 2'd1, 0, 2'd0, 0, 3'd1, 0, 0, 0, 5'b0), 30'h0, 30'h100};
    bus = 6'b000000;
    @(negedge clk);
    check("R7 hold while enable low", {1'b0, fb_out}, 2'b01);
    bus = 6'b000100;
    @(negedge clk);
    check("R7 load while enable high", {1'b0, fb_out}, 2'b00);

    // R8 asynchronous clear from term3 (bus bit3); first load a 1
    cfg = {mkctl(1, 0, 1, 0, 2'd1, 0, 2'd1, 3'd3, 0, 0, 0, 0, 5'b0), 30'h0, 30'h200000};
    bus = '0;
    @(negedge clk);
    check("R8 preload", {1'b0, fb_out}, 2'b01);
    bus = 6'b001000;
    #2;
    check("R8 clear before edge", {1'b0, fb_out}, 2'b00);
    @(negedge clk);
    bus = '0;
    @(negedge clk);
    check("R8 reload after clear", {1'b0, fb_out}, 2'b01);

    // R12 toggle: operand term0 = bus bit0 = fed-back Q, sum = empty term1 = 1
    cfg = {mkctl(1, 1, 0, 0, 2'd1, 0, 2'd2, 0, 0, 0, 0, 3'd0, 5'b00010), 30'h0, 30'h1};
    for (int k = 0; k < 6; k++) begin
      prev = fb_out;
      bus = {5'b0, prev};
      @(negedge clk);
      check($sformatf("R12 toggle step %0d", k), {pad_drv, fb_out}, {~prev, ~prev});
      check($sformatf("R12 model step %0d", k), {cas_out, pad_drv, pad_en, fb_out},
            ref_out(cfg, bus, 1'b0, 1'b0, ~prev));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule